// File: doc/BRIEF.md
# Power-up Reset Sequencer

This block produces the single active-high reset for a small microcontroller core. Four sources can request reset: a one-shot power-on event, a supply-low (brown-out) level, an active-low external reset pin, and a watchdog request. All of them run in the domain of a slow internal oscillator of about 31 kHz. Supply detection and oscillator generation are done elsewhere and arrive here as plain digital inputs. Each one passes through a two-flop synchronizer before the sequencer uses it.

Power events get more than the plain request. After a power-on event, or once the supply returns above threshold, the reset is stretched by a power-up timer of `TMR_TICKS` slow-clock ticks. With the default of 2048 ticks this is roughly 64 ms. Pin and watchdog resets only last as long as their request and never start this timer. The external pin is sampled through a digital glitch filter, and a configuration bit can disconnect the pin entirely. When the pin is disconnected, the block asks the pad for its weak pull-up instead. Sticky cause flags record why the core was last reset, so that firmware can read them and clear them.

Top module: `pwrup_rst_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, `core_rst` is 1 and `cause_flags` is 0. The power-on input is armed on exit from that reset.
- R2: With `cfg_tmr_off`=0, an armed rising edge on `por_pulse` asserts `core_rst`. `core_rst` is first seen low after the rising edge that comes `TMR_TICKS`+3 edges after the edge that first samples the pulse, and it stays high the whole time the timer runs.
- R3: With `cfg_tmr_off`=1, the power-up timer is bypassed. `core_rst` after a power event is first low 3 edges after the edge that first samples the event.
- R4: While `bor_low` is 1, `core_rst` stays 1. The stretch starts from the release of `bor_low`, with the same edge count as R2 (timer on) or R3 (timer off).
- R5: `por_pulse` is one-shot. A second rising edge is ignored until `por_rearm` has been asserted, and after that a new edge is accepted.
- R6: The filtered pin goes low only after `PIN_FILT` consecutive low samples. It goes high only after the same number of consecutive high samples. A low pulse of fewer than `PIN_FILT` slow-clock cycles causes no reset.
- R7: With `cfg_pin_en`=0, the pin is treated as always high, so no pin reset occurs whatever the pin does, and `pullup_en` is 1. With `cfg_pin_en`=1, `pullup_en` is 0.
- R8: `wdt_req` holds `core_rst` high only while it is asserted, plus the synchronizer latency. It never starts the power-up timer and never sets the pin flag. A 3-cycle request leaves `core_rst` first low on the 6th edge counted from the edge that first samples it.
- R9: `cause_flags` bit 0 marks power-on, bit 1 marks brown-out, bit 2 marks pin and bit 3 marks watchdog. The bits are sticky and are cleared by a one-cycle `flag_clr`. A power-on event sets the value to exactly 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low initialisation of the sequencer |
| por_pulse | input | 1 | Power-on request, asynchronous, rising edge used |
| por_rearm | input | 1 | Rearms power-on detection, asynchronous level |
| bor_low | input | 1 | Supply below threshold, asynchronous level |
| pin_n_raw | input | 1 | External reset pin, active-low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, level |
| cfg_tmr_off | input | 1 | 1 bypasses the power-up timer |
| cfg_pin_en | input | 1 | 1 connects the external pin, 0 disconnects it |
| flag_clr | input | 1 | Clears the cause flags, one slow-clock cycle |
| core_rst | output | 1 | Active-high core reset |
| pullup_en | output | 1 | Weak pull-up request for the pin pad |
| cause_flags | output | 4 | Sticky reset causes {wdt, pin, bor, por} |

## Verification
The bench runs a small configuration: 8 timer ticks and a pin filter of 4 samples. In that configuration it counts the exact edge at which reset is released.

- **Timer path:** it triggers power-on and brown-out release with the timer both enabled and bypassed. This separates a timed stretch from a pass-through release.
- **Pin filter:** it sweeps the length of the pin low pulse from 1 to 6 cycles. This pins down the exact filter threshold, one sample either side.
- **Pin disable:** the same pin stimulus is repeated with the pin disconnected.
- **Timer arming:** a watchdog pulse and a power-on edge without rearm show that neither path arms the timer.
- **Cause flags:** the flag pattern is compared after every event, and after the clear strobe.

// File: rtl/pwrup_rst_pkg.sv
// Shared constants for the power-up reset sequencer: cause flag layout.
package pwrup_rst_pkg;
    localparam int CAUSE_W   = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_BOR = 1;
    localparam int CAUSE_PIN = 2;
    localparam int CAUSE_WDT = 3;
endpackage

// File: rtl/rst_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is implied.
// INIT gives each bit's value during synchronous reset.
module rst_sync2 #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Capture then re-register every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= INIT;
            q_sync <= INIT;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/rst_pin_filter.sv
// Digital glitch filter for the synchronized reset pin.
// The output level changes only after TAPS consecutive samples at the
// opposite level. When pin_en is low the pin is ignored and reads high.
// Assumes pin_in is already synchronous to clk and TAPS >= 2.
module rst_pin_filter #(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_en,
    input  logic pin_in,
    output logic lvl_o
);
    localparam int CW = $clog2(TAPS);

    logic [CW-1:0] run_len;

    // Count consecutive disagreeing samples; flip the level at TAPS.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_en) begin
            lvl_o   <= 1'b1;
            run_len <= '0;
        end else if (pin_in == lvl_o) begin
            run_len <= '0;
        end else if (run_len == CW'(TAPS - 1)) begin
            lvl_o   <= pin_in;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/rst_pwrup_timer.sv
// Power-up stretch timer. A start pulse, or the end of a brown-out hold,
// launches a TICKS-cycle run unless bypass is set. While the brown-out
// hold is active the timer is parked and a pending run is remembered.
// Assumes TICKS >= 2 and that start comes only from power events.
module rst_pwrup_timer #(
    parameter int TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic bor_hold,
    input  logic start,
    output logic run_o,
    output logic pend_o
);
    localparam int CW = $clog2(TICKS);

    logic [CW-1:0] ticks;

    // Park under brown-out, launch on a power event, count to TICKS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o  <= 1'b0;
            pend_o <= 1'b0;
            ticks  <= '0;
        end else if (bor_hold) begin
            run_o  <= 1'b0;
            pend_o <= 1'b1;
            ticks  <= '0;
        end else if (start || pend_o) begin
            run_o  <= !bypass;
            pend_o <= 1'b0;
            ticks  <= '0;
        end else if (run_o) begin
            if (bypass || ticks == CW'(TICKS - 1)) begin
                run_o <= 1'b0;
                ticks <= '0;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrup_rst_ctrl.sv
// Power-up reset sequencer top. Merges power-on, brown-out, filtered pin
// and watchdog requests into a registered active-high core reset. Power
// events are stretched by the power-up timer. Cause flags are kept sticky.
// Assumes all clocked logic runs on the slow oscillator and that rst_n
// is synchronous to it.
module pwrup_rst_ctrl
    import pwrup_rst_pkg::*;
#(
    parameter int TMR_TICKS = 2048,
    parameter int PIN_FILT  = 4
) (
    input  logic               clk_slow,
    input  logic               rst_n,
    input  logic               por_pulse,
    input  logic               por_rearm,
    input  logic               bor_low,
    input  logic               pin_n_raw,
    input  logic               wdt_req,
    input  logic               cfg_tmr_off,
    input  logic               cfg_pin_en,
    input  logic               flag_clr,
    output logic               core_rst,
    output logic               pullup_en,
    output logic [CAUSE_W-1:0] cause_flags
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_vec, syn_vec;
    logic por_s, bor_s, pin_s, rearm_s, wdt_s;
    logic por_prev, por_armed, por_evt;
    logic pin_lvl, pin_lo;
    logic tmr_run, tmr_pend;

    assign raw_vec = {wdt_req, por_rearm, pin_n_raw, bor_low, por_pulse};
    assign {wdt_s, rearm_s, pin_s, bor_s, por_s} = syn_vec;

    rst_sync2 #(.W(NSYNC), .INIT(5'b00100)) u_sync (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (syn_vec)
    );

    rst_pin_filter #(.TAPS(PIN_FILT)) u_pin (
        .clk    (clk_slow),
        .rst_n  (rst_n),
        .pin_en (cfg_pin_en),
        .pin_in (pin_s),
        .lvl_o  (pin_lvl)
    );

    assign pin_lo    = !pin_lvl;
    assign pullup_en = !cfg_pin_en;
    assign por_evt   = por_s && !por_prev && por_armed;

    rst_pwrup_timer #(.TICKS(TMR_TICKS)) u_tmr (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .bypass   (cfg_tmr_off),
        .bor_hold (bor_s),
        .start    (por_evt),
        .run_o    (tmr_run),
        .pend_o   (tmr_pend)
    );

    // One-shot power-on detection with explicit rearm.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            por_prev  <= 1'b0;
            por_armed <= 1'b1;
        end else begin
            por_prev <= por_s;
            if (rearm_s)      por_armed <= 1'b1;
            else if (por_evt) por_armed <= 1'b0;
        end
    end

    // Registered merge of every reset source.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) core_rst <= 1'b1;
        else        core_rst <= bor_s || por_evt || tmr_pend || tmr_run
                                || pin_lo || wdt_s;
    end

    // Sticky cause flags; power-on wipes the others, events beat the clear.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            cause_flags <= '0;
        end else if (por_evt) begin
            cause_flags            <= '0;
            cause_flags[CAUSE_POR] <= 1'b1;
        end else begin
            cause_flags <= flag_clr ? '0 : cause_flags;
            if (bor_s)  cause_flags[CAUSE_BOR] <= 1'b1;
            if (pin_lo) cause_flags[CAUSE_PIN] <= 1'b1;
            if (wdt_s)  cause_flags[CAUSE_WDT] <= 1'b1;
        end
    end
endmodule

// File: rtl/pwrup_rst_ctrl_chk.sv
// Assertion checker for the power-up reset sequencer, bound to the top.
// Observes internal synchronized requests and timer state against the
// registered core reset and the cause flags.
module pwrup_rst_ctrl_chk (
    input logic       clk_slow,
    input logic       rst_n,
    input logic       core_rst,
    input logic       cfg_tmr_off,
    input logic       tmr_run,
    input logic       bor_s,
    input logic       wdt_s,
    input logic       pin_lo,
    input logic       por_evt,
    input logic [3:0] cause_flags
);
    // R4
    bor_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        bor_s |=> core_rst);
    // R8
    wdt_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wdt_s |=> core_rst);
    // R2
    tmr_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        tmr_run |=> core_rst);
    // R3
    tmr_bypass_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        cfg_tmr_off |=> !tmr_run);
    // R6
    pin_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        pin_lo |=> core_rst);
    // R9
    por_flag_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        por_evt |=> (cause_flags == 4'b0001));
    // R2
    rel_after_tmr_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $fell(core_rst) |-> !$past(tmr_run));
endmodule

bind pwrup_rst_ctrl pwrup_rst_ctrl_chk u_chk (
    .clk_slow    (clk_slow),
    .rst_n       (rst_n),
    .core_rst    (core_rst),
    .cfg_tmr_off (cfg_tmr_off),
    .tmr_run     (tmr_run),
    .bor_s       (bor_s),
    .wdt_s       (wdt_s),
    .pin_lo      (pin_lo),
    .por_evt     (por_evt),
    .cause_flags (cause_flags)
);

// File: tb/tb_pwrup_rst_ctrl.sv
// Self-checking bench for the power-up reset sequencer, small configuration.
module tb_pwrup_rst_ctrl;
    localparam int TT = 8;
    localparam int PF = 4;

    logic clk = 1'b0;
    logic rst_n, por_pulse, por_rearm, bor_low, pin_n_raw, wdt_req;
    logic cfg_tmr_off, cfg_pin_en, flag_clr;
    logic core_rst, pullup_en;
    logic [3:0] cause_flags;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = !clk;

    pwrup_rst_ctrl #(.TMR_TICKS(TT), .PIN_FILT(PF)) dut (
        .clk_slow (clk), .rst_n (rst_n), .por_pulse (por_pulse),
        .por_rearm (por_rearm), .bor_low (bor_low), .pin_n_raw (pin_n_raw),
        .wdt_req (wdt_req), .cfg_tmr_off (cfg_tmr_off), .cfg_pin_en (cfg_pin_en),
        .flag_clr (flag_clr), .core_rst (core_rst), .pullup_en (pullup_en),
        .cause_flags (cause_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Count edges until core_rst, having been high, is seen low again.
    task automatic time_release(input int por_len, input int wdt_len, output int k);
        bit seen;
        seen = core_rst;
        k = 0;
        while (k < 200) begin
            @(posedge clk); @(negedge clk);
            k++;
            if (k == por_len) por_pulse = 1'b0;
            if (k == wdt_len) wdt_req = 1'b0;
            if (core_rst) seen = 1'b1;
            else if (seen) break;
        end
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        cycles(1);
        flag_clr = 1'b0;
        cycles(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        bit seen;
        rst_n = 1'b0; por_pulse = 1'b0; por_rearm = 1'b0; bor_low = 1'b0;
        pin_n_raw = 1'b1; wdt_req = 1'b0; cfg_tmr_off = 1'b0; cfg_pin_en = 1'b1;
        flag_clr = 1'b0;
        @(negedge clk);
        cycles(4);
        chk("R1 core_rst in reset", int'(core_rst), 1);
        chk("R1 flags in reset", int'(cause_flags), 0);
        rst_n = 1'b1;
        cycles(6);
        chk("R1 released idle", int'(core_rst), 0);
        chk("R7 pullup off when pin connected", int'(pullup_en), 0);

        // R2: timed power-on release
        por_pulse = 1'b1;
        time_release(1, 0, k);
        chk("R2 por release edge", k, TT + 4);
        chk("R9 por flags", int'(cause_flags), 1);

        // R5: no rearm, second edge ignored
        cycles(3);
        por_pulse = 1'b1;
        seen = 1'b0;
        repeat (TT + 6) begin cycles(1); seen |= core_rst; end
        por_pulse = 1'b0;
        chk("R5 por without rearm ignored", int'(seen), 0);

        // R5, R3: rearm then bypassed power-on
        cycles(3);
        por_rearm = 1'b1; cycles(3); por_rearm = 1'b0; cycles(4);
        cfg_tmr_off = 1'b1;
        por_pulse = 1'b1;
        time_release(1, 0, k);
        chk("R3 R5 rearmed por bypass edge", k, 4);

        // R4: brown-out hold, then bypassed and timed release
        clear_flags();
        chk("R9 flags cleared", int'(cause_flags), 0);
        bor_low = 1'b1;
        cycles(6);
        chk("R4 held during bor", int'(core_rst), 1);
        chk("R9 bor flag", int'(cause_flags), 2);
        bor_low = 1'b0;
        time_release(0, 0, k);
        chk("R4 bor release bypass", k, 4);
        cfg_tmr_off = 1'b0;
        cycles(2);
        bor_low = 1'b1;
        cycles(5);
        bor_low = 1'b0;
        time_release(0, 0, k);
        chk("R4 bor release timed", k, TT + 4);

        // R6: sweep pin low length around the filter threshold
        for (int d = 1; d <= PF + 2; d++) begin
            clear_flags();
            pin_n_raw = 1'b0;
            repeat (d) @(posedge clk);
            @(negedge clk);
            pin_n_raw = 1'b1;
            seen = core_rst;
            repeat (14) begin cycles(1); seen |= core_rst; end
            chk($sformatf("R6 pin reset len %0d", d), int'(seen), (d >= PF) ? 1 : 0);
            chk($sformatf("R6 pin flag len %0d", d), int'(cause_flags), (d >= PF) ? 4 : 0);
            chk("R6 pin released", int'(core_rst), 0);
        end

        // R7: pin disconnected
        clear_flags();
        cfg_pin_en = 1'b0;
        cycles(1);
        chk("R7 pullup on when pin disabled", int'(pullup_en), 1);
        pin_n_raw = 1'b0;
        seen = 1'b0;
        repeat (12) begin cycles(1); seen |= core_rst; end
        pin_n_raw = 1'b1;
        chk("R7 disabled pin no reset", int'(seen), 0);
        chk("R7 disabled pin no flag", int'(cause_flags), 0);
        cfg_pin_en = 1'b1;
        cycles(4);

        // R8: watchdog reset, short and untimed
        wdt_req = 1'b1;
        time_release(0, 3, k);
        chk("R8 wdt release edge", k, 6);
        chk("R8 wdt flag only", int'(cause_flags), 8);

        // R9: power-on wipes the watchdog flag
        por_rearm = 1'b1; cycles(3); por_rearm = 1'b0; cycles(3);
        por_pulse = 1'b1;
        time_release(1, 0, k);
        chk("R9 por wipes other flags", int'(cause_flags), 1);
        chk("R2 second timed por edge", k, TT + 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule